// File: doc/BRIEF.md
# Control Endpoint Status Register

This block is the CPU-visible control and status register for endpoint zero of a USB device controller. It sits between a byte-wide CPU register bus and the USB protocol engine. The engine reports events with one-cycle strobes: a valid token arrived, a packet went out, a protocol violation occurred, a STALL handshake was issued, and the status stage completed. The CPU acknowledges and arms the endpoint by writing the register.

The block holds five endpoint flags: OUT-ready, IN-ready, sent-stall, force-stall and data-end. Each flag has its own rule for being set and cleared. While OUT-ready is pending, the block tells the engine that it may not enter a data phase. Any of three endpoint events sets a sticky interrupt flag when endpoint-zero interrupts are enabled. The block also holds the IN max-packet length as the byte count minus one. It gives the engine both the stored value and the decoded byte count, from 1 to 256.

Top module: `ep0_ctl_status`

## Requirements
- R1: After a synchronous reset, all five flags and the interrupt flag read 0, the max-packet value reads 0x08, and the decoded byte count is 9.
- R2: OUT-ready (address 0, bit 0) is set one cycle after `eng_token_rx`. It is cleared only by a CPU write to address 0 with bit 6 set. A write of one to bit 0 does not clear it. A token in the same cycle as the clearing write leaves it set.
- R3: `eng_data_phase_ok` is low in every cycle in which OUT-ready is set, and high otherwise.
- R4: Data-end (address 0, bit 4) is set by a CPU write of one to that bit, which may come in the same write that clears OUT-ready. `eng_status_done` clears it, but a set in the same cycle wins.
- R5: IN-ready (address 0, bit 1) is set by a CPU write of one and cleared by `eng_pkt_sent`. A write of zero to bit 1 leaves it unchanged.
- R6: Sent-stall (address 0, bit 2) is set by `eng_proto_err` and cleared by a CPU write of one to bit 2. A violation in the same cycle as the clear leaves it set.
- R7: Force-stall (address 0, bit 3) is set by a CPU write of one and drives `eng_force_stall`. `eng_stall_done` clears it.
- R8: When `irq_en` is high, a token, a successful send while IN-ready is set, or a protocol violation sets the interrupt flag (address 2, bit 0) one cycle later. `irq_ep0` follows this flag. A write of one to address 2, bit 0 clears it, but a new event in the same cycle wins.
- R9: While `irq_en` is low, no event sets the interrupt flag.
- R10: Address 1 holds the IN max-packet value as length minus one. A write takes effect on the next cycle. `maxp_bytes` equals the value plus one, so 0xFF gives 256 and 0x00 gives 1.
- R11: Address 0 bits 7 to 5 read 0, including the write-only bit 6. Address 2 bits 7 to 1 read 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | CPU write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_en | input | 1 | Endpoint-zero interrupt enable |
| eng_token_rx | input | 1 | Engine: valid endpoint-zero token received |
| eng_pkt_sent | input | 1 | Engine: IN packet sent successfully |
| eng_proto_err | input | 1 | Engine: transfer aborted with STALL after a protocol violation |
| eng_stall_done | input | 1 | Engine: forced STALL has been issued |
| eng_status_done | input | 1 | Engine: status stage finished |
| eng_data_phase_ok | output | 1 | Engine may enter a data phase |
| eng_force_stall | output | 1 | Request to STALL the current setup transfer |
| maxp_m1 | output | 8 | IN max-packet value (length minus one) |
| maxp_bytes | output | 9 | Decoded IN packet length in bytes |
| irq_ep0 | output | 1 | Endpoint-zero interrupt request |

## Verification
The bench drives each flag's set and clear on the same edge. A design that let the CPU clear win would lose a token, a violation or an interrupt. It also writes ones to the wrong bit and zeros to the right bit. A design that cleared OUT-ready from bit 0, or that let a zero write drop IN-ready, would show the flag missing on the next read. It checks that the interrupt stays quiet while disabled and that a send with IN-ready already clear raises nothing. An off-by-one length decode would report 255 instead of 256 at 0xFF, and 0 instead of 1 at 0x00.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 2;
    localparam int NUM_FLAGS = 5;
    localparam int LEN_W     = DATA_W + 1;

    localparam logic [ADDR_W-1:0] ADDR_CSR  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MAXP = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_IRQ  = 2'd2;

    // bit positions inside the endpoint register
    localparam int BIT_OPR  = 0;
    localparam int BIT_IPR  = 1;
    localparam int BIT_SST  = 2;
    localparam int BIT_FST  = 3;
    localparam int BIT_DE   = 4;
    localparam int BIT_SOPR = 6;
    localparam int BIT_IRQ  = 0;

    typedef enum logic {
        FK_HWSET_W1C,    // engine sets, CPU writes one to clear
        FK_SWSET_HWCLR   // CPU writes one to set, engine clears
    } flag_kind_e;

    // packed so that each field lands on its register bit
    typedef struct packed {
        logic de;
        logic fst;
        logic sst;
        logic ipr;
        logic opr;
    } ep0_flags_t;

    typedef struct packed {
        logic token_rx;
        logic pkt_sent;
        logic proto_err;
        logic stall_done;
        logic status_done;
    } eng_evt_t;

    function automatic flag_kind_e kind_of(input int idx);
        if (idx == BIT_OPR || idx == BIT_SST)
            return FK_HWSET_W1C;
        return FK_SWSET_HWCLR;
    endfunction

    function automatic logic [LEN_W-1:0] len_from_m1(input logic [DATA_W-1:0] m1);
        return {1'b0, m1} + {{(LEN_W-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/ep0_flag_cell.sv
module ep0_flag_cell
    import ep0_csr_pkg::*;
#(
    parameter flag_kind_e KIND = FK_HWSET_W1C
) (
    input  logic clk,
    input  logic rst,
    input  logic hw_evt,
    input  logic sw_one,
    output logic q
);

    logic nxt;

    generate
        if (KIND == FK_HWSET_W1C) begin : g_hw_set
            // engine set dominates a simultaneous CPU clear
            assign nxt = hw_evt | (q & ~sw_one);
        end else begin : g_sw_set
            // CPU set dominates a simultaneous engine clear
            assign nxt = sw_one | (q & ~hw_evt);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= nxt;
    end

endmodule

// File: rtl/ep0_flag_bank.sv
module ep0_flag_bank
    import ep0_csr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  eng_evt_t             evt,
    input  logic [NUM_FLAGS-1:0] csr_ones,
    input  logic                 irq_clr,
    input  logic                 irq_en,
    output ep0_flags_t           flags,
    output logic                 irq_flag
);

    logic [NUM_FLAGS-1:0] hw_ev;
    logic [NUM_FLAGS-1:0] q;
    logic                 irq_set;

    always_comb begin
        hw_ev          = '0;
        hw_ev[BIT_OPR] = evt.token_rx;
        hw_ev[BIT_IPR] = evt.pkt_sent;
        hw_ev[BIT_SST] = evt.proto_err;
        hw_ev[BIT_FST] = evt.stall_done;
        hw_ev[BIT_DE]  = evt.status_done;
    end

    generate
        for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
            ep0_flag_cell #(.KIND(kind_of(i))) i_cell (
                .clk    (clk),
                .rst    (rst),
                .hw_evt (hw_ev[i]),
                .sw_one (csr_ones[i]),
                .q      (q[i])
            );
        end
    endgenerate

    assign flags = ep0_flags_t'(q);

    // an IN completion only counts when a packet was actually armed
    assign irq_set = irq_en & (evt.token_rx
                             | (q[BIT_IPR] & evt.pkt_sent)
                             | evt.proto_err);

    ep0_flag_cell #(.KIND(FK_HWSET_W1C)) i_irq_cell (
        .clk    (clk),
        .rst    (rst),
        .hw_evt (irq_set),
        .sw_one (irq_clr),
        .q      (irq_flag)
    );

endmodule

// File: rtl/ep0_maxpkt_reg.sv
module ep0_maxpkt_reg
    import ep0_csr_pkg::*;
#(
    parameter logic [DATA_W-1:0] RESET_VAL = 8'h08
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value,
    output logic [LEN_W-1:0]  bytes
);

    always_ff @(posedge clk) begin
        if (rst)     value <= RESET_VAL;
        else if (wr) value <= wdata;
    end

    assign bytes = len_from_m1(value);

endmodule

// File: rtl/ep0_ctl_status.sv
module ep0_ctl_status
    import ep0_csr_pkg::*;
#(
    parameter logic [DATA_W-1:0] MAXP_RESET = 8'h08
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_en,
    input  logic              eng_token_rx,
    input  logic              eng_pkt_sent,
    input  logic              eng_proto_err,
    input  logic              eng_stall_done,
    input  logic              eng_status_done,
    output logic              eng_data_phase_ok,
    output logic              eng_force_stall,
    output logic [DATA_W-1:0] maxp_m1,
    output logic [LEN_W-1:0]  maxp_bytes,
    output logic              irq_ep0
);

    localparam int PAD_W = DATA_W - NUM_FLAGS;

    logic                 wr_csr, wr_maxp, wr_irq;
    logic [NUM_FLAGS-1:0] csr_ones;
    eng_evt_t             evt;
    ep0_flags_t           flags;
    logic                 irq_flag;

    assign wr_csr  = bus_wr && (bus_addr == ADDR_CSR);
    assign wr_maxp = bus_wr && (bus_addr == ADDR_MAXP);
    assign wr_irq  = bus_wr && (bus_addr == ADDR_IRQ);

    // OUT-ready is acknowledged through its separate write-only bit
    always_comb begin
        csr_ones          = '0;
        csr_ones[BIT_OPR] = bus_wdata[BIT_SOPR];
        csr_ones[BIT_IPR] = bus_wdata[BIT_IPR];
        csr_ones[BIT_SST] = bus_wdata[BIT_SST];
        csr_ones[BIT_FST] = bus_wdata[BIT_FST];
        csr_ones[BIT_DE]  = bus_wdata[BIT_DE];
        csr_ones          = csr_ones & {NUM_FLAGS{wr_csr}};
    end

    assign evt = '{token_rx:    eng_token_rx,
                   pkt_sent:    eng_pkt_sent,
                   proto_err:   eng_proto_err,
                   stall_done:  eng_stall_done,
                   status_done: eng_status_done};

    ep0_flag_bank i_flags (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .csr_ones (csr_ones),
        .irq_clr  (wr_irq & bus_wdata[BIT_IRQ]),
        .irq_en   (irq_en),
        .flags    (flags),
        .irq_flag (irq_flag)
    );

    ep0_maxpkt_reg #(.RESET_VAL(MAXP_RESET)) i_maxp (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_maxp),
        .wdata (bus_wdata),
        .value (maxp_m1),
        .bytes (maxp_bytes)
    );

    always_comb begin
        case (bus_addr)
            ADDR_CSR:  bus_rdata = {{PAD_W{1'b0}}, flags};
            ADDR_MAXP: bus_rdata = maxp_m1;
            ADDR_IRQ:  bus_rdata = {{(DATA_W-1){1'b0}}, irq_flag};
            default:   bus_rdata = '0;
        endcase
    end

    assign eng_data_phase_ok = ~flags.opr;
    assign eng_force_stall   = flags.fst;
    assign irq_ep0           = irq_flag;

endmodule

// File: rtl/ep0_csr_checker.sv
module ep0_csr_checker
    import ep0_csr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_en,
    input logic              eng_token_rx,
    input logic              eng_pkt_sent,
    input logic              eng_proto_err,
    input logic              eng_stall_done,
    input logic              eng_status_done,
    input logic              eng_data_phase_ok,
    input logic              eng_force_stall,
    input logic [DATA_W-1:0] maxp_m1,
    input logic              irq_ep0,
    input ep0_flags_t        flags
);

    logic csr_w;
    assign csr_w = bus_wr && (bus_addr == ADDR_CSR);

    a_r2_opr_set: assert property (@(posedge clk) disable iff (rst)
        eng_token_rx |=> flags.opr);

    a_r2_opr_hold: assert property (@(posedge clk) disable iff (rst)
        flags.opr && !(csr_w && bus_wdata[BIT_SOPR]) |=> flags.opr);

    a_r3_no_data_phase: assert property (@(posedge clk) disable iff (rst)
        eng_token_rx |=> !eng_data_phase_ok);

    a_r4_de_clear: assert property (@(posedge clk) disable iff (rst)
        flags.de && eng_status_done && !(csr_w && bus_wdata[BIT_DE]) |=> !flags.de);

    a_r5_ipr_clear: assert property (@(posedge clk) disable iff (rst)
        flags.ipr && eng_pkt_sent && !(csr_w && bus_wdata[BIT_IPR]) |=> !flags.ipr);

    a_r5_ipr_hold: assert property (@(posedge clk) disable iff (rst)
        flags.ipr && !eng_pkt_sent |=> flags.ipr);

    a_r6_sst_set: assert property (@(posedge clk) disable iff (rst)
        eng_proto_err |=> flags.sst);

    a_r7_fst_set: assert property (@(posedge clk) disable iff (rst)
        csr_w && bus_wdata[BIT_FST] |=> eng_force_stall);

    a_r7_fst_clear: assert property (@(posedge clk) disable iff (rst)
        flags.fst && eng_stall_done && !(csr_w && bus_wdata[BIT_FST]) |=> !eng_force_stall);

    a_r8_irq_set: assert property (@(posedge clk) disable iff (rst)
        irq_en && eng_proto_err |=> irq_ep0);

    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        !irq_en && !irq_ep0 |=> !irq_ep0);

    a_r10_maxp_write: assert property (@(posedge clk) disable iff (rst)
        bus_wr && (bus_addr == ADDR_MAXP) |=> maxp_m1 == $past(bus_wdata));

endmodule

bind ep0_ctl_status ep0_csr_checker i_ep0_chk (
    .clk               (clk),
    .rst               (rst),
    .bus_wr            (bus_wr),
    .bus_addr          (bus_addr),
    .bus_wdata         (bus_wdata),
    .irq_en            (irq_en),
    .eng_token_rx      (eng_token_rx),
    .eng_pkt_sent      (eng_pkt_sent),
    .eng_proto_err     (eng_proto_err),
    .eng_stall_done    (eng_stall_done),
    .eng_status_done   (eng_status_done),
    .eng_data_phase_ok (eng_data_phase_ok),
    .eng_force_stall   (eng_force_stall),
    .maxp_m1           (maxp_m1),
    .irq_ep0           (irq_ep0),
    .flags             (flags)
);

// File: tb/test_ep0_ctl_status.sv
`timescale 1ns/1ps
module test_ep0_ctl_status;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_wr;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       irq_en;
    logic       eng_token_rx, eng_pkt_sent, eng_proto_err;
    logic       eng_stall_done, eng_status_done;
    logic       eng_data_phase_ok, eng_force_stall;
    logic [7:0] maxp_m1;
    logic [8:0] maxp_bytes;
    logic       irq_ep0;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    logic m_opr, m_ipr, m_sst, m_fst, m_de, m_irq;
    logic [7:0] m_maxp;

    always #4 clk = ~clk;

    ep0_ctl_status i_ep0_ctl_status (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_en(irq_en),
        .eng_token_rx(eng_token_rx), .eng_pkt_sent(eng_pkt_sent),
        .eng_proto_err(eng_proto_err), .eng_stall_done(eng_stall_done),
        .eng_status_done(eng_status_done), .eng_data_phase_ok(eng_data_phase_ok),
        .eng_force_stall(eng_force_stall), .maxp_m1(maxp_m1),
        .maxp_bytes(maxp_bytes), .irq_ep0(irq_ep0)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_read(input logic [1:0] a);
        case (a)
            2'd0:    return {3'b000, m_de, m_fst, m_sst, m_ipr, m_opr};
            2'd1:    return m_maxp;
            2'd2:    return {7'd0, m_irq};
            default: return 8'h00;
        endcase
    endfunction

    // next reference state from the current inputs, following R2 R4 R5 R6 R7 R8 R10
    task automatic ref_step();
        logic w0, w1, w2;
        logic n_irq;
        w0 = bus_wr && bus_addr == 2'd0;
        w1 = bus_wr && bus_addr == 2'd1;
        w2 = bus_wr && bus_addr == 2'd2;
        n_irq = (irq_en && (eng_token_rx || (m_ipr && eng_pkt_sent) || eng_proto_err))
              || (m_irq && !(w2 && bus_wdata[0]));
        m_opr = eng_token_rx || (m_opr && !(w0 && bus_wdata[6]));
        m_ipr = (w0 && bus_wdata[1]) || (m_ipr && !eng_pkt_sent);
        m_sst = eng_proto_err || (m_sst && !(w0 && bus_wdata[2]));
        m_fst = (w0 && bus_wdata[3]) || (m_fst && !eng_stall_done);
        m_de  = (w0 && bus_wdata[4]) || (m_de && !eng_status_done);
        m_irq = n_irq;
        if (w1) m_maxp = bus_wdata;
    endtask

    task automatic check_all();
        chk("R3 data_phase_ok", {15'd0, eng_data_phase_ok}, {15'd0, !m_opr});
        chk("R7 force_stall", {15'd0, eng_force_stall}, {15'd0, m_fst});
        chk("R8 irq_ep0", {15'd0, irq_ep0}, {15'd0, m_irq});
        chk("R10 maxp_m1", {8'd0, maxp_m1}, {8'd0, m_maxp});
        chk("R10 maxp_bytes", {7'd0, maxp_bytes}, {7'd0, m_maxp} + 16'd1);
        chk("R2 R4 R5 R6 R11 read", {8'd0, bus_rdata}, {8'd0, ref_read(bus_addr)});
    endtask

    // one clock: check, drive, advance reference
    task automatic cycle(input logic wr, input logic [1:0] a, input logic [7:0] wd,
                         input logic tok, input logic sent, input logic perr,
                         input logic sdone, input logic stdone, input logic en);
        @(negedge clk);
        check_all();
        bus_wr = wr; bus_addr = a; bus_wdata = wd;
        eng_token_rx = tok; eng_pkt_sent = sent; eng_proto_err = perr;
        eng_stall_done = sdone; eng_status_done = stdone; irq_en = en;
        ref_step();
    endtask

    task automatic idle(input logic [1:0] a);
        cycle(1'b0, a, 8'h00, 0, 0, 0, 0, 0, 1'b1);
    endtask

    task automatic expect_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
        idle(a);
        #1;
        chk(tag, {8'd0, bus_rdata}, {8'd0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd7321);
        rst = 1'b1; bus_wr = 0; bus_addr = 0; bus_wdata = 0; irq_en = 1;
        eng_token_rx = 0; eng_pkt_sent = 0; eng_proto_err = 0;
        eng_stall_done = 0; eng_status_done = 0;
        m_opr = 0; m_ipr = 0; m_sst = 0; m_fst = 0; m_de = 0; m_irq = 0; m_maxp = 8'h08;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        expect_read(2'd0, 8'h00, "R1 csr");
        expect_read(2'd1, 8'h08, "R1 maxp");
        expect_read(2'd2, 8'h00, "R1 irq");
        chk("R1 bytes", {7'd0, maxp_bytes}, 16'd9);

        // R2 R3: token, wrong-bit write, proper clear, and set-beats-clear
        cycle(0, 0, 8'h00, 1, 0, 0, 0, 0, 1);
        cycle(1, 0, 8'h01, 0, 0, 0, 0, 0, 1);
        expect_read(2'd0, 8'h01, "R2 opr kept after bit0 write");
        chk("R3 gate low", {15'd0, eng_data_phase_ok}, 16'd0);
        cycle(1, 0, 8'h40, 0, 0, 0, 0, 0, 1);
        expect_read(2'd0, 8'h00, "R2 opr cleared");
        cycle(1, 0, 8'h40, 1, 0, 0, 0, 0, 1);
        expect_read(2'd0, 8'h01, "R2 set wins");

        // R4: clear OUT-ready and set data-end together, then status done
        cycle(1, 0, 8'h50, 0, 0, 0, 0, 0, 1);
        expect_read(2'd0, 8'h10, "R4 de with sopr");
        cycle(1, 0, 8'h10, 0, 0, 0, 0, 1, 1);
        expect_read(2'd0, 8'h10, "R4 set beats status done");
        cycle(0, 0, 8'h00, 0, 0, 0, 0, 1, 1);
        expect_read(2'd0, 8'h00, "R4 de cleared");

        // R5 R8: arm IN, zero write ignored, send clears and interrupts
        cycle(1, 2, 8'h01, 0, 0, 0, 0, 0, 1);
        cycle(1, 0, 8'h02, 0, 0, 0, 0, 0, 1);
        cycle(1, 0, 8'h00, 0, 0, 0, 0, 0, 1);
        expect_read(2'd0, 8'h02, "R5 ipr kept");
        chk("R8 no irq yet", {15'd0, irq_ep0}, 16'd0);
        cycle(0, 0, 8'h00, 0, 1, 0, 0, 0, 1);
        expect_read(2'd0, 8'h00, "R5 ipr cleared");
        chk("R8 irq on send", {15'd0, irq_ep0}, 16'd1);
        cycle(1, 2, 8'h01, 0, 1, 0, 0, 0, 1);
        expect_read(2'd2, 8'h00, "R8 send without ipr no irq");

        // R6 R8: violation, zero write, W1C, and set-beats-clear for sst and irq
        cycle(0, 0, 8'h00, 0, 0, 1, 0, 0, 1);
        cycle(1, 0, 8'h00, 0, 0, 0, 0, 0, 1);
        expect_read(2'd0, 8'h04, "R6 sst kept");
        cycle(1, 0, 8'h04, 0, 0, 0, 0, 0, 1);
        expect_read(2'd0, 8'h00, "R6 sst cleared");
        cycle(1, 0, 8'h04, 0, 0, 1, 0, 0, 1);
        expect_read(2'd0, 8'h04, "R6 set wins");
        cycle(1, 2, 8'h01, 0, 0, 1, 0, 0, 1);
        expect_read(2'd2, 8'h01, "R8 set wins");
        cycle(1, 2, 8'h01, 0, 0, 0, 0, 0, 1);
        expect_read(2'd2, 8'h00, "R8 irq cleared");

        // R7
        cycle(1, 0, 8'h08, 0, 0, 0, 0, 0, 1);
        idle(2'd0); #1;
        chk("R7 force stall on", {15'd0, eng_force_stall}, 16'd1);
        cycle(0, 0, 8'h00, 0, 0, 0, 1, 0, 1);
        idle(2'd0); #1;
        chk("R7 force stall off", {15'd0, eng_force_stall}, 16'd0);

        // R9: disabled interrupts stay quiet
        cycle(1, 0, 8'h44, 1, 0, 1, 0, 0, 0);
        cycle(0, 0, 8'h00, 1, 0, 1, 0, 0, 0);
        idle(2'd2); #1;
        chk("R9 irq quiet", {15'd0, irq_ep0}, 16'd0);

        // R10 length edges, R11 unused reads
        cycle(1, 1, 8'hFF, 0, 0, 0, 0, 0, 1);
        idle(2'd1); #1;
        chk("R10 bytes 256", {7'd0, maxp_bytes}, 16'd256);
        cycle(1, 1, 8'h00, 0, 0, 0, 0, 0, 1);
        idle(2'd1); #1;
        chk("R10 bytes 1", {7'd0, maxp_bytes}, 16'd1);
        cycle(1, 0, 8'hFF, 0, 0, 0, 0, 0, 1);
        expect_read(2'd0, 8'h1A, "R11 csr upper bits zero");
        cycle(1, 3, 8'hFF, 0, 0, 0, 0, 0, 1);
        expect_read(2'd3, 8'h00, "R11 addr3 zero");

        // random mix
        begin
            logic en;
            en = 1'b1;
            for (int i = 0; i < 4000; i++) begin
                if (i % 64 == 0) en = ($urandom % 4) != 0;
                cycle(($urandom % 10) < 3, 2'($urandom % 4), 8'($urandom),
                      ($urandom % 6) == 0, ($urandom % 5) == 0, ($urandom % 8) == 0,
                      ($urandom % 5) == 0, ($urandom % 5) == 0, en);
            end
        end
        idle(2'd0);
        @(negedge clk);
        check_all();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule